// File: doc/BRIEF.md
# Packed BCD Integer Converter

This block moves a signed integer between two encodings: an 80-bit packed-decimal operand and a 64-bit two's-complement value. The decimal operand carries eighteen decimal digits in its low nine bytes, two digits per byte. The least significant pair sits in byte 0. Bit 7 of the top byte (byte 9) is the sign. A one-bit direction input selects the conversion. Loading turns the decimal operand into an integer. Storing turns an integer into the decimal operand.

Each conversion takes one byte per clock. Loading starts at byte 8 and multiplies the running value by one hundred before adding the next byte's two digits. Storing takes the magnitude, splits off the remainder modulo one hundred each cycle, and fills bytes from byte 0 upward. A start pulse begins a conversion. A one-cycle done pulse marks the cycle in which the results appear. Each conversion also reports one flag: an invalid digit on a load, or a magnitude that does not fit on a store.

Top module: `bcd_int_conv`

## Requirements
- R1: After a synchronous active-low reset, busy, done, bad_digit and overflow are 0, and int_out and dec_out are all zeros.
- R2: A load (dir = 0) gives int_out = the sum over k = 0..8 of (high nibble of byte k × 10 + low nibble of byte k) × 100^k. Byte k is dec_in[8k+7:8k]. The high nibble is the more significant digit.
- R3: A load negates the accumulated value in two's complement when dec_in[79] is 1. Bits 78:72 of dec_in have no effect on the result.
- R4: A store (dir = 1) writes dec_out[79:72] = 8'h80 for a negative int_in and 8'h00 otherwise. Byte k of dec_out (k = 0..8) holds (r / 10) in bits 7:4 and (r mod 10) in bits 3:0, where r = (|int_in| / 100^k) mod 100.
- R5: On a store, every byte above the most significant nonzero digit pair, up to byte 8, is 8'h00. A zero input gives an all-zero dec_out.
- R6: A store whose magnitude exceeds 999999999999999999 sets overflow. In that case bytes 9, 8 and 7 of dec_out are 8'hFF and bytes 6 to 0 are 8'h00. This includes the most negative integer. A magnitude of exactly 999999999999999999 converts normally with overflow at 0.
- R7: A load sets bad_digit when any nibble of bytes 0 to 8 exceeds 9. The conversion still completes with the arithmetic of R2 applied to the raw nibble values.
- R8: After the edge that accepts start, busy stays high for nine cycles. On the ninth following edge, busy falls, done rises for exactly one cycle, and the results appear. Outputs change at no other time.
- R9: A start raised while busy is ignored: the running conversion and its result are unaffected. A start in the done cycle is accepted.
- R10: A load updates int_out and bad_digit and clears overflow, leaving dec_out unchanged. A store updates dec_out and overflow and clears bad_digit, leaving int_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| dir | input | 1 | 0 = decimal to integer, 1 = integer to decimal |
| dec_in | input | 80 | Packed decimal operand for a load |
| int_in | input | 64 | Two's-complement operand for a store |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| int_out | output | 64 | Integer result of the last load |
| dec_out | output | 80 | Packed decimal result of the last store |
| bad_digit | output | 1 | Last load saw a nibble above 9 |
| overflow | output | 1 | Last store magnitude did not fit in 18 digits |

## Verification
The hardest situations to reach are the ones that depend on timing rather than data. One is a second start arriving in the middle of a running conversion. Another is a new start landing exactly in the done cycle. The stimulus covers both. It pulses start with different operands three cycles into a conversion, and it launches each following operation on the done cycle of the previous one. The 18-digit boundary needs exact operands: 999999999999999999, 10^18, and the most negative integer, whose magnitude has no positive counterpart.

// File: rtl/bcd_conv_pkg.sv
// Shared types and constants for the packed BCD integer converter.
// Assumes the integer side is at most 64 bits wide.
package bcd_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } conv_state_t;

    // Largest magnitude representable in nbytes digit pairs: 100^nbytes - 1
    function automatic logic [63:0] dec_limit(input int nbytes);
        logic [63:0] p;
        p = 64'd1;
        for (int i = 0; i < nbytes; i++) p = p * 64'd100;
        return p - 64'd1;
    endfunction

endpackage

// File: rtl/bcd_pack_step.sv
// One decimal-to-binary step: folds a packed digit pair into the
// running value as acc*100 + tens*10 + ones and flags non-decimal nibbles.
// Assumes the caller presents bytes most significant first.
module bcd_pack_step #(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0] acc_in,
    input  logic [7:0]       pair_in,
    output logic [INT_W-1:0] acc_out,
    output logic             nibble_bad
);
    localparam logic [INT_W-1:0] K100 = INT_W'(100);
    localparam logic [INT_W-1:0] K10  = INT_W'(10);

    // Multiply-accumulate of one digit pair
    always_comb begin
        acc_out = acc_in * K100 + INT_W'(pair_in[7:4]) * K10 + INT_W'(pair_in[3:0]);
    end

    // Detect a nibble outside 0..9
    always_comb begin
        nibble_bad = (pair_in[7:4] > 4'd9) || (pair_in[3:0] > 4'd9);
    end
endmodule

// File: rtl/bcd_unpack_step.sv
// One binary-to-decimal step: divides the remaining magnitude by 100
// with a constant divisor and emits the remainder as a packed digit pair.
// Assumes an unsigned magnitude input.
module bcd_unpack_step #(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0] mag_in,
    output logic [INT_W-1:0] mag_out,
    output logic [7:0]       pair_out
);
    localparam logic [INT_W-1:0] K100 = INT_W'(100);

    logic [6:0] rem100;

    // Quotient and remainder by one hundred
    always_comb begin
        mag_out = mag_in / K100;
        rem100  = 7'(mag_in - mag_out * K100);
    end

    // Split the remainder into tens and ones nibbles
    always_comb begin
        pair_out = {4'(rem100 / 7'd10), 4'(rem100 % 7'd10)};
    end
endmodule

// File: rtl/bcd_seq_ctrl.sv
// Sequencer: accepts start only when idle, counts one step per byte,
// and issues a single-cycle done after the last step.
// Assumes steps = number of digit bytes.
module bcd_seq_ctrl
    import bcd_conv_pkg::*;
#(
    parameter int STEPS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir,
    output logic accept,
    output logic busy,
    output logic is_store,
    output logic last_step,
    output logic done
);
    localparam int IDX_W = $clog2(STEPS);

    conv_state_t      state;
    logic [IDX_W-1:0] idx;

    // Combinational handshake decode
    always_comb begin
        busy      = (state != ST_IDLE);
        is_store  = (state == ST_STORE);
        accept    = start && (state == ST_IDLE);
        last_step = busy && (idx == '0);
    end

    // State and byte-index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else if (accept) begin
            state <= dir ? ST_STORE : ST_LOAD;
            idx   <= IDX_W'(STEPS - 1);
        end else if (busy) begin
            if (idx == '0) state <= ST_IDLE;
            else           idx   <= idx - 1'b1;
        end
    end

    // Completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_step;
    end
endmodule

// File: rtl/bcd_int_conv.sv
// Packed BCD <-> two's-complement integer converter, one byte per cycle.
// Load walks bytes from most to least significant; store fills from byte 0.
// Assumes DIGIT_BYTES*2 decimal digits fit in INT_W-1 magnitude bits.
module bcd_int_conv
    import bcd_conv_pkg::*;
#(
    parameter int INT_W       = 64,
    parameter int DIGIT_BYTES = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       dir,
    input  logic [8*DIGIT_BYTES+7:0]   dec_in,
    input  logic [INT_W-1:0]           int_in,
    output logic                       busy,
    output logic                       done,
    output logic [INT_W-1:0]           int_out,
    output logic [8*DIGIT_BYTES+7:0]   dec_out,
    output logic                       bad_digit,
    output logic                       overflow
);
    localparam int DIG_W = 8 * DIGIT_BYTES;
    localparam int DEC_W = DIG_W + 8;
    localparam logic [INT_W-1:0] MAG_LIMIT = INT_W'(dec_limit(DIGIT_BYTES));
    localparam logic [DEC_W-1:0] INDEF = {24'hFFFFFF, {(DEC_W-24){1'b0}}};

    logic             accept, is_store, last_step;
    logic [DIG_W-1:0] src_sr, dst_sr;
    logic [INT_W-1:0] acc, acc_pack, acc_div, in_mag;
    logic [7:0]       pair_out;
    logic             neg_r, ovf_r, bad_acc, pair_bad;
    logic             sign_pad_unused;

    assign sign_pad_unused = ^dec_in[DEC_W-2:DIG_W];

    bcd_seq_ctrl #(.STEPS(DIGIT_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .accept(accept), .busy(busy), .is_store(is_store),
        .last_step(last_step), .done(done)
    );

    bcd_pack_step #(.INT_W(INT_W)) u_pack (
        .acc_in(acc), .pair_in(src_sr[DIG_W-1 -: 8]),
        .acc_out(acc_pack), .nibble_bad(pair_bad)
    );

    bcd_unpack_step #(.INT_W(INT_W)) u_unpack (
        .mag_in(acc), .mag_out(acc_div), .pair_out(pair_out)
    );

    // Absolute value of the integer operand
    always_comb begin
        in_mag = int_in[INT_W-1] ? (~int_in + 1'b1) : int_in;
    end

    // Working registers: operand capture and per-byte stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sr  <= '0;
            dst_sr  <= '0;
            acc     <= '0;
            neg_r   <= 1'b0;
            ovf_r   <= 1'b0;
            bad_acc <= 1'b0;
        end else if (accept) begin
            bad_acc <= 1'b0;
            dst_sr  <= '0;
            if (dir) begin
                neg_r <= int_in[INT_W-1];
                acc   <= in_mag;
                ovf_r <= (in_mag > MAG_LIMIT);
            end else begin
                neg_r  <= dec_in[DEC_W-1];
                src_sr <= dec_in[DIG_W-1:0];
                acc    <= '0;
                ovf_r  <= 1'b0;
            end
        end else if (busy) begin
            if (is_store) begin
                acc    <= acc_div;
                dst_sr <= {pair_out, dst_sr[DIG_W-1:8]};
            end else begin
                acc     <= acc_pack;
                src_sr  <= {src_sr[DIG_W-9:0], 8'h00};
                bad_acc <= bad_acc | pair_bad;
            end
        end
    end

    // Result registers, written only on the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_out   <= '0;
            dec_out   <= '0;
            bad_digit <= 1'b0;
            overflow  <= 1'b0;
        end else if (last_step) begin
            if (is_store) begin
                overflow  <= ovf_r;
                bad_digit <= 1'b0;
                dec_out   <= ovf_r ? INDEF
                                   : {neg_r ? 8'h80 : 8'h00, pair_out, dst_sr[DIG_W-1:8]};
            end else begin
                overflow  <= 1'b0;
                bad_digit <= bad_acc | pair_bad;
                int_out   <= neg_r ? (~acc_pack + 1'b1) : acc_pack;
            end
        end
    end
endmodule

// File: rtl/bcd_int_conv_chk.sv
// Property checker for the packed BCD converter, bound to the top module.
// Assumes default 80-bit decimal port width.
module bcd_int_conv_chk #(
    parameter int DEC_W = 80,
    parameter int INT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [DEC_W-1:0] dec_out,
    input logic [INT_W-1:0] int_out,
    input logic             bad_digit,
    input logic             overflow
);
    localparam logic [DEC_W-1:0] INDEF = {24'hFFFFFF, {(DEC_W-24){1'b0}}};

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(int_out) && $stable(dec_out))); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R9
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R9
    AST_OVF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) (done && overflow) |-> (dec_out == INDEF)); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(overflow && bad_digit)); // R10
endmodule

bind bcd_int_conv bcd_int_conv_chk #(.DEC_W(8*DIGIT_BYTES+8), .INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .dec_out(dec_out), .int_out(int_out), .bad_digit(bad_digit), .overflow(overflow)
);

// File: tb/bcd_int_conv_test.sv
`timescale 1ns/1ps
module bcd_int_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [79:0] dec_in = '0;
    logic [63:0] int_in = '0;
    logic        busy, done, bad_digit, overflow;
    logic [63:0] int_out;
    logic [79:0] dec_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    bcd_int_conv uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .dec_in(dec_in), .int_in(int_in), .busy(busy), .done(done),
        .int_out(int_out), .dec_out(dec_out),
        .bad_digit(bad_digit), .overflow(overflow)
    );

    // Reference arithmetic from the requirements
    function automatic logic [64:0] ref_load(input logic [79:0] dv);
        logic [63:0] acc = 64'd0;
        logic        bad = 1'b0;
        for (int i = 8; i >= 0; i--) begin
            acc = acc * 64'd100 + 64'(dv[i*8+4 +: 4]) * 64'd10 + 64'(dv[i*8 +: 4]);
            if (dv[i*8+4 +: 4] > 4'd9 || dv[i*8 +: 4] > 4'd9) bad = 1'b1;
        end
        if (dv[79]) acc = -acc;
        return {bad, acc};
    endfunction

    function automatic logic [80:0] ref_store(input logic [63:0] iv);
        logic [63:0] mag = iv[63] ? -iv : iv;
        logic [79:0] o = '0;
        logic [63:0] r;
        if (mag > 64'd999999999999999999)
            return {1'b1, 24'hFFFFFF, 56'h0};
        for (int i = 0; i < 9; i++) begin
            r = mag % 64'd100;
            o[i*8 +: 8] = {4'(r / 64'd10), 4'(r % 64'd10)};
            mag = mag / 64'd100;
        end
        o[79:72] = iv[63] ? 8'h80 : 8'h00;
        return {1'b0, o};
    endfunction

    // Cycle-level reference model
    logic        m_busy, m_done, m_bad, m_ovf, p_dir;
    logic [63:0] m_int, p_int;
    logic [79:0] m_dec, p_dec;
    logic        p_bad, p_ovf;
    int          m_cnt;
    string       m_tag, p_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_int = '0; m_dec = '0;
            m_bad = 0; m_ovf = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_tag = p_tag;
                    if (p_dir) begin m_dec = p_dec; m_ovf = p_ovf; m_bad = 0; end
                    else begin m_int = p_int; m_bad = p_bad; m_ovf = 0; end
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 9; p_dir = dir; p_tag = cur_tag;
                {p_bad, p_int} = ref_load(dec_in);
                {p_ovf, p_dec} = ref_store(int_in);
            end
        end
    end

    task automatic cmp(input string tag, input string what, input logic [79:0] act, input logic [79:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R8", "busy", 80'(busy), 80'(m_busy));
            cmp("R8", "done", 80'(done), 80'(m_done));
            cmp(m_tag, "int_out", 80'(int_out), 80'(m_int));
            cmp(m_tag, "dec_out", dec_out, m_dec);
            cmp(m_tag, "bad_digit", 80'(bad_digit), 80'(m_bad));
            cmp(m_tag, "overflow", 80'(overflow), 80'(m_ovf));
        end
    end

    // One operation; returns on the done cycle so the next start lands there (R9)
    task automatic op(input logic d, input logic [79:0] dv, input logic [63:0] iv, input string tag);
        cur_tag = tag; start = 1'b1; dir = d; dec_in = dv; int_in = iv;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);                                          // R1 reset state compared here
        op(1'b0, {8'h00, 72'h123456789012345678}, 64'd0, "R2");
        op(1'b0, {8'h00, 72'h999999999999999999}, 64'd0, "R2");
        op(1'b0, {8'h85, 72'h000000000000000042}, 64'd0, "R3");  // sign with junk bits
        op(1'b0, {8'h7F, 72'h000000000000000042}, 64'd0, "R3");  // junk bits, positive
        op(1'b0, {8'h00, 72'h00000000000000001A}, 64'd0, "R7");
        op(1'b0, {8'h80, 72'hF00000000000000009}, 64'd0, "R7");
        op(1'b1, '0, 64'd1234567, "R4");
        op(1'b1, '0, -64'd987654321098765432, "R4");
        op(1'b1, '0, 64'd0, "R5");
        op(1'b1, '0, 64'd5, "R5");
        op(1'b1, '0, 64'd1000000000000000000, "R6");
        op(1'b1, '0, 64'h8000000000000000, "R6");
        op(1'b1, '0, 64'd999999999999999999, "R6");
        op(1'b1, '0, -64'd1000000000000000000, "R6");
        op(1'b0, {8'h00, 72'h000000000000000777}, 64'd0, "R10"); // clears overflow, keeps dec_out
        op(1'b1, '0, 64'd31, "R10");                              // keeps int_out
        // R9: second start mid-run with different operands must be ignored
        cur_tag = "R9"; start = 1'b1; dir = 1'b0; dec_in = {8'h00, 72'h000000000000000314};
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; dir = 1'b1; int_in = -64'd5; dec_in = {8'h80, 72'h999};
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule